// File: doc/BRIEF.md
# SPI Receive Buffer and Status Flag Controller

This block sits beside the serial shift engine of an SPI port and keeps the last character that the engine completed. Each completion strobe copies the received word into a holding register, raises a receive-complete flag, and raises an overrun flag when the previous character was never consumed. Both flags appear as image bits above the data in the word that the bus reads back. The block drives two interrupt lines and a DMA request level.

Software has two read views of the same word. A read through the consuming view clears the flags and marks the data as taken. A read through the debug view returns the same word and changes nothing. Flags are also cleared by writing ones to a clear strobe, by dropping the module enable, or by reset.

An internal "unread data" marker is deliberately not cleared by the module enable. After the enable is toggled, software must perform one dummy consuming read. If it does not, the next character reports an overrun.

Top module: `spi_rxbuf_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the buffer, both flags, the unread marker, `rx_irq`, `ovr_irq` and `dma_req` are all 0.
- R2: A `ld_stb` pulse while `en`=1 copies `ld_data` into read-word bits 15:0 and sets the receive flag, which reads back at bit 16, on the same clock edge.
- R3: A load while the unread marker is set, with no consuming read in that cycle, sets the overrun flag, which reads back at bit 17.
- R4: A consuming read (`rd_buf_sel`=1) returns the word as it was before the read. From the next cycle, the receive flag, the overrun flag and the unread marker are clear.
- R5: A debug read (`rd_dbg_sel`=1) returns the same word as a consuming read and leaves the flags and the unread marker unchanged.
- R6: A `w1c_stb` pulse clears the receive flag where `w1c_bits[0]`=1 and the overrun flag where `w1c_bits[1]`=1. The clear wins over a set in the same cycle, and the unread marker is unaffected.
- R7: While `en`=0, both flags are held at 0 and loads are ignored; the buffer keeps its value. The unread marker survives, so after re-enabling, a load with no intervening consuming read sets the overrun flag.
- R8: `rx_irq` and `ovr_irq` each equal the AND of their flag and their enable, delayed by one clock register.
- R9: With `en`=1 and `dma_en`=1, a load sets `dma_req`. It stays high until a consuming read or a `tx_wr_stb` pulse; a debug read does not clear it, and `dma_en`=0 or `en`=0 forces it to 0 at the next edge.
- R10: A load and a consuming read in the same cycle leave the receive flag at 1, the overrun flag at 0, and the unread marker set.
- R11: When neither read select is high, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Module enable |
| rx_ie | input | 1 | Receive interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| dma_en | input | 1 | DMA request enable |
| ld_stb | input | 1 | Character-complete strobe from the shift engine |
| ld_data | input | 16 | Right-justified received character |
| rd_buf_sel | input | 1 | Consuming read of the buffer word |
| rd_dbg_sel | input | 1 | Non-destructive debug read of the buffer word |
| rd_data | output | 32 | Read word: data 15:0, receive flag 16, overrun flag 17 |
| w1c_stb | input | 1 | Flag clear write strobe |
| w1c_bits | input | 2 | Bit 0 clears the receive flag, bit 1 clears the overrun flag |
| tx_wr_stb | input | 1 | Transmit data write, releases the DMA request |
| rx_irq | output | 1 | Receive interrupt |
| ovr_irq | output | 1 | Overrun interrupt |
| dma_req | output | 1 | DMA request level |

## Verification
The hardest state to reach from the ports is a stale unread marker paired with cleared flags. In that state the read word shows no pending data, yet the next character will report an overrun. The stimulus reaches it by loading a character, dropping and restoring `en` without a consuming read, and then loading again; it repeats the sequence with a dummy read in between to show the overrun disappear. A swept control pattern over all strobe combinations also forces same-cycle collisions, such as load with clear, or load with consuming read, against a bench model built from the requirements.

// File: rtl/spi_rxbuf_pkg.sv
// Package: shared widths, interrupt line indices and the flag record
// for the SPI receive buffer controller.
package spi_rxbuf_pkg;
    localparam int unsigned RXB_DATA_W = 16;
    localparam int unsigned RXB_BUS_W  = 32;
    localparam int unsigned RXB_NUM_IRQ = 2;
    localparam int unsigned RXB_IRQ_RX  = 0;
    localparam int unsigned RXB_IRQ_OVR = 1;

    typedef struct packed {
        logic ovr;
        logic rxf;
    } rxb_flags_t;
endpackage

// File: rtl/spi_rxbuf_store.sv
// Module: holding register for the last completed character.
// Assumes ld_en is already qualified with the module enable.
module spi_rxbuf_store #(
    parameter int unsigned DATA_W = spi_rxbuf_pkg::RXB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] buf_q
);
    // Capture received data on each qualified completion.
    always_ff @(posedge clk) begin
        if (!rst_n)     buf_q <= '0;
        else if (ld_en) buf_q <= ld_data;
    end

    AST_BUF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> buf_q == $past(ld_data)); // R2
endmodule

// File: rtl/spi_rxbuf_flags.sv
// Module: receive-complete flag, overrun flag and the unread marker.
// Assumes ld_en is qualified with en. The unread marker ignores en and
// write-1-to-clear; only a consuming read or reset clears it.
module spi_rxbuf_flags (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     ld_en,
    input  logic                     rd_buf,
    input  logic                     w1c_rx,
    input  logic                     w1c_ovr,
    output spi_rxbuf_pkg::rxb_flags_t flags_q
);
    logic unread_q;

    // Track whether the buffer holds a character not yet consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)      unread_q <= 1'b0;
        else if (ld_en)  unread_q <= 1'b1;
        else if (rd_buf) unread_q <= 1'b0;
    end

    // Receive-complete flag: clear has priority over set, set over read.
    always_ff @(posedge clk) begin
        if (!rst_n)              flags_q.rxf <= 1'b0;
        else if (!en || w1c_rx)  flags_q.rxf <= 1'b0;
        else if (ld_en)          flags_q.rxf <= 1'b1;
        else if (rd_buf)         flags_q.rxf <= 1'b0;
    end

    // Overrun flag: set when a character lands on unconsumed data.
    always_ff @(posedge clk) begin
        if (!rst_n)                             flags_q.ovr <= 1'b0;
        else if (!en || w1c_ovr)                flags_q.ovr <= 1'b0;
        else if (ld_en && unread_q && !rd_buf)  flags_q.ovr <= 1'b1;
        else if (rd_buf)                        flags_q.ovr <= 1'b0;
    end

    AST_OVR_ON_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && unread_q && !rd_buf && !w1c_ovr) |=> flags_q.ovr); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_buf && !ld_en) |=> (!flags_q.rxf && !flags_q.ovr && !unread_q)); // R4
    AST_W1C_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        w1c_rx |=> !flags_q.rxf); // R6
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!flags_q.rxf && !flags_q.ovr)); // R7
    AST_LOAD_READ_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && rd_buf && !w1c_rx) |=> (flags_q.rxf && !flags_q.ovr && unread_q)); // R10
endmodule

// File: rtl/spi_rxbuf_irq.sv
// Module: one registered interrupt line per flag, gated by its enable.
// Assumes flag and enable vectors share the same index order.
module spi_rxbuf_irq #(
    parameter int unsigned NUM_IRQ = spi_rxbuf_pkg::RXB_NUM_IRQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] flag_vec,
    input  logic [NUM_IRQ-1:0] ie_vec,
    output logic [NUM_IRQ-1:0] irq_q
);
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        // Register the gated flag onto its interrupt line.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q[g] <= 1'b0;
            else        irq_q[g] <= flag_vec[g] & ie_vec[g];
        end

        AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_q[g]) |-> $past(flag_vec[g] && ie_vec[g])); // R8
    end
endmodule

// File: rtl/spi_rxbuf_dma.sv
// Module: DMA request level, raised per received character and released
// by a consuming read or a transmit write. Assumes ld_en is qualified.
module spi_rxbuf_dma (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dma_en,
    input  logic ld_en,
    input  logic rd_buf,
    input  logic tx_wr,
    output logic dma_req_q
);
    // Hold the request from character arrival until it is serviced.
    always_ff @(posedge clk) begin
        if (!rst_n)                 dma_req_q <= 1'b0;
        else if (!(en && dma_en))   dma_req_q <= 1'b0;
        else if (ld_en)             dma_req_q <= 1'b1;
        else if (rd_buf || tx_wr)   dma_req_q <= 1'b0;
    end

    AST_DMA_RISE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req_q) |-> $past(ld_en)); // R9
    AST_DMA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_q && (rd_buf || tx_wr) && !ld_en) |=> !dma_req_q); // R9
endmodule

// File: rtl/spi_rxbuf_ctrl.sv
// Module: top of the SPI receive buffer controller. Qualifies loads
// with the enable, places the flag images above the data in the read
// word and routes flags to interrupt and DMA logic.
// Assumes the shift engine delivers data right-justified.
module spi_rxbuf_ctrl #(
    parameter int unsigned DATA_W = spi_rxbuf_pkg::RXB_DATA_W,
    parameter int unsigned BUS_W  = spi_rxbuf_pkg::RXB_BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rx_ie,
    input  logic              ovr_ie,
    input  logic              dma_en,
    input  logic              ld_stb,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              rd_buf_sel,
    input  logic              rd_dbg_sel,
    output logic [BUS_W-1:0]  rd_data,
    input  logic              w1c_stb,
    input  logic [1:0]        w1c_bits,
    input  logic              tx_wr_stb,
    output logic              rx_irq,
    output logic              ovr_irq,
    output logic              dma_req
);
    import spi_rxbuf_pkg::*;

    localparam int unsigned RXF_BIT = DATA_W;
    localparam int unsigned OVR_BIT = DATA_W + 1;

    logic                   ld_en;
    logic [DATA_W-1:0]      buf_q;
    rxb_flags_t             flags_q;
    logic [RXB_NUM_IRQ-1:0] flag_vec;
    logic [RXB_NUM_IRQ-1:0] ie_vec;
    logic [RXB_NUM_IRQ-1:0] irq_vec;

    assign ld_en = ld_stb & en;

    spi_rxbuf_store #(.DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data), .buf_q(buf_q)
    );

    spi_rxbuf_flags flags_i (
        .clk(clk), .rst_n(rst_n), .en(en), .ld_en(ld_en), .rd_buf(rd_buf_sel),
        .w1c_rx(w1c_stb & w1c_bits[0]), .w1c_ovr(w1c_stb & w1c_bits[1]),
        .flags_q(flags_q)
    );

    // Order flags and enables by interrupt line index.
    always_comb begin
        flag_vec = '0;
        ie_vec   = '0;
        flag_vec[RXB_IRQ_RX]  = flags_q.rxf;
        flag_vec[RXB_IRQ_OVR] = flags_q.ovr;
        ie_vec[RXB_IRQ_RX]    = rx_ie;
        ie_vec[RXB_IRQ_OVR]   = ovr_ie;
    end

    spi_rxbuf_irq #(.NUM_IRQ(RXB_NUM_IRQ)) irq_i (
        .clk(clk), .rst_n(rst_n), .flag_vec(flag_vec), .ie_vec(ie_vec), .irq_q(irq_vec)
    );

    assign rx_irq  = irq_vec[RXB_IRQ_RX];
    assign ovr_irq = irq_vec[RXB_IRQ_OVR];

    spi_rxbuf_dma dma_i (
        .clk(clk), .rst_n(rst_n), .en(en), .dma_en(dma_en), .ld_en(ld_en),
        .rd_buf(rd_buf_sel), .tx_wr(tx_wr_stb), .dma_req_q(dma_req)
    );

    // Assemble the read word for either view; zero when unselected.
    always_comb begin
        rd_data = '0;
        if (rd_buf_sel || rd_dbg_sel) begin
            rd_data[DATA_W-1:0] = buf_q;
            rd_data[RXF_BIT]    = flags_q.rxf;
            rd_data[OVR_BIT]    = flags_q.ovr;
        end
    end

    AST_DEBUG_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dbg_sel && !rd_buf_sel && !ld_stb && !w1c_stb && en) |=> $stable(flags_q)); // R5
endmodule

// File: tb/spi_rxbuf_ctrl_tb.sv
`timescale 1ns/1ps
module spi_rxbuf_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, rx_ie = 1'b0, ovr_ie = 1'b0, dma_en = 1'b0;
    logic        ld_stb = 1'b0;
    logic [15:0] ld_data = '0;
    logic        rd_buf_sel = 1'b0, rd_dbg_sel = 1'b0;
    logic [31:0] rd_data;
    logic        w1c_stb = 1'b0;
    logic [1:0]  w1c_bits = '0;
    logic        tx_wr_stb = 1'b0;
    logic        rx_irq, ovr_irq, dma_req;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_buf;
    logic m_rxf, m_ovr, m_unread, m_dma, m_rxirq, m_ovrirq;

    always #2.5 clk = ~clk;

    spi_rxbuf_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .rx_ie(rx_ie), .ovr_ie(ovr_ie),
        .dma_en(dma_en), .ld_stb(ld_stb), .ld_data(ld_data),
        .rd_buf_sel(rd_buf_sel), .rd_dbg_sel(rd_dbg_sel), .rd_data(rd_data),
        .w1c_stb(w1c_stb), .w1c_bits(w1c_bits), .tx_wr_stb(tx_wr_stb),
        .rx_irq(rx_irq), .ovr_irq(ovr_irq), .dma_req(dma_req)
    );

    function automatic logic [31:0] m_word();
        return {14'b0, m_ovr, m_rxf, m_buf};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Bench model of the requirements, advanced at each rising edge.
    task automatic model_edge();
        logic le;
        le = ld_stb & en;
        if (!rst_n) begin
            m_buf = '0; m_rxf = 0; m_ovr = 0; m_unread = 0;
            m_dma = 0; m_rxirq = 0; m_ovrirq = 0;
        end else begin
            m_rxirq  = m_rxf & rx_ie;   // R8
            m_ovrirq = m_ovr & ovr_ie;
            if (!(en && dma_en)) m_dma = 0;  // R9
            else if (le) m_dma = 1;
            else if (rd_buf_sel || tx_wr_stb) m_dma = 0;
            if (!en || (w1c_stb && w1c_bits[1])) m_ovr = 0;  // R3 R6 R7
            else if (le && m_unread && !rd_buf_sel) m_ovr = 1;
            else if (rd_buf_sel) m_ovr = 0;
            if (!en || (w1c_stb && w1c_bits[0])) m_rxf = 0;  // R2 R4 R10
            else if (le) m_rxf = 1;
            else if (rd_buf_sel) m_rxf = 0;
            if (le) m_unread = 1;
            else if (rd_buf_sel) m_unread = 0;
            if (le) m_buf = ld_data;
        end
    endtask

    // One clock: check read word, clock, then check registered outputs.
    task automatic step();
        #0.5;
        chk("R4 R5 R11 rd_data", rd_data, (rd_buf_sel || rd_dbg_sel) ? m_word() : 32'h0);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R8 rx_irq", {31'b0, rx_irq}, {31'b0, m_rxirq});
        chk("R8 ovr_irq", {31'b0, ovr_irq}, {31'b0, m_ovrirq});
        chk("R9 dma_req", {31'b0, dma_req}, {31'b0, m_dma});
    endtask

    task automatic clr();
        ld_stb = 0; rd_buf_sel = 0; rd_dbg_sel = 0;
        w1c_stb = 0; w1c_bits = 0; tx_wr_stb = 0;
    endtask

    task automatic do_ld(input logic [15:0] d);
        clr(); ld_stb = 1; ld_data = d; step(); clr();
    endtask

    task automatic do_rdb();
        clr(); rd_buf_sel = 1; step(); clr();
    endtask

    task automatic peek(input string tag, input logic [31:0] exp);
        clr(); rd_dbg_sel = 1; #0.1;
        chk(tag, rd_data, exp);
        rd_dbg_sel = 0;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        clr(); rst_n = 0;
        step(); step();
        rd_dbg_sel = 1; #0.1;
        chk("R1 rd_data in reset", rd_data, 32'h0);
        chk("R1 outputs", {29'b0, rx_irq, ovr_irq, dma_req}, 32'h0);
        clr();
        rst_n = 1; en = 1; rx_ie = 1; ovr_ie = 1; dma_en = 1;
        step();
        peek("R1 after reset", 32'h0);

        do_ld(16'hA5C3);
        peek("R2 load", 32'h0001_A5C3);
        chk("R9 dma after load", {31'b0, dma_req}, 32'h1);
        chk("R8 irq lags flag", {31'b0, rx_irq}, 32'h0);
        step();
        chk("R8 irq one cycle later", {31'b0, rx_irq}, 32'h1);

        clr(); rd_dbg_sel = 1; step(); clr();
        peek("R5 debug read keeps flags", 32'h0001_A5C3);
        chk("R9 debug read keeps dma", {31'b0, dma_req}, 32'h1);

        clr(); rd_buf_sel = 1; #0.1;
        chk("R4 consuming read value", rd_data, 32'h0001_A5C3);
        step(); clr();
        peek("R4 flags cleared", 32'h0000_A5C3);
        chk("R9 read releases dma", {31'b0, dma_req}, 32'h0);

        do_ld(16'h1111);
        do_ld(16'h2222);
        peek("R3 overrun", 32'h0003_2222);
        step();
        chk("R8 ovr_irq", {31'b0, ovr_irq}, 32'h1);

        clr(); ld_stb = 1; ld_data = 16'h3333; w1c_stb = 1; w1c_bits = 2'b11;
        step(); clr();
        peek("R6 clear beats set", 32'h0000_3333);
        do_ld(16'h4444);
        peek("R6 unread kept after clear", 32'h0003_4444);

        do_rdb();
        do_ld(16'h5555);
        clr(); ld_stb = 1; ld_data = 16'h6666; rd_buf_sel = 1; step(); clr();
        peek("R10 load with read", 32'h0001_6666);

        en = 0; step();
        peek("R7 disable clears flags", 32'h0000_6666);
        do_ld(16'h7777);
        peek("R7 load ignored", 32'h0000_6666);
        en = 1; step();
        do_ld(16'h8888);
        peek("R7 stale unread overrun", 32'h0003_8888);
        do_rdb();
        en = 0; step(); en = 1; step();
        do_rdb();
        do_ld(16'h9999);
        peek("R7 dummy read avoids overrun", 32'h0001_9999);

        clr(); tx_wr_stb = 1; step(); clr();
        chk("R9 tx write releases dma", {31'b0, dma_req}, 32'h0);
        dma_en = 0; do_ld(16'hAAAA);
        chk("R9 dma_en low", {31'b0, dma_req}, 32'h0);
        dma_en = 1;
        clr(); #0.1;
        chk("R11 no select", rd_data, 32'h0);

        for (int c = 0; c < 4096; c++) begin
            logic [11:0] v;
            v = c[11:0];
            ld_stb = v[0]; rd_buf_sel = v[1]; rd_dbg_sel = v[2];
            en = ~(v[3] & v[4] & v[5]);
            dma_en = ~v[3]; rx_ie = v[4]; ovr_ie = v[5];
            w1c_stb = v[6]; w1c_bits = v[8:7]; tx_wr_stb = v[9] & v[10];
            ld_data = 16'(c * 40503);
            step();
        end

        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ld_stb = lfsr[0] | lfsr[5];
            rd_buf_sel = lfsr[1] & lfsr[6];
            rd_dbg_sel = lfsr[2];
            en = ~(lfsr[3] & lfsr[7] & lfsr[9]);
            dma_en = ~(lfsr[4] & lfsr[8]);
            rx_ie = lfsr[11] | lfsr[3];
            ovr_ie = lfsr[12] | lfsr[1];
            w1c_stb = lfsr[13] & lfsr[14];
            w1c_bits = lfsr[15:14];
            tx_wr_stb = lfsr[10] & lfsr[2];
            ld_data = lfsr ^ 16'h5A3C;
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule